// File: doc/BRIEF.md
# Asynchronous EPROM Read Bus Controller

This block lets a synchronous host read 16-bit words from a small array of asynchronous, EPROM-style memory devices. These devices share one data bus. The host presents a word address, a bank number and a speed-grade code through a valid/ready handshake. The controller then runs one read cycle on the memory side. It drives the address, pulls low the chip enable of the selected bank only, and lowers the output enable that all devices share once the enable-to-data window allows it. It samples the bus when every access window has elapsed and returns the word with a one-cycle valid strobe.

The access windows are counted in clock cycles and rounded up from nanosecond figures for a configurable clock period. There are three preset sets. The address-to-data and select-to-data windows are equal. The output-enable-to-data window is shorter, so output enable is held back by the difference. After a read, the controller remembers which bank it released and that bank's float time. A following read to a different bank must not lower output enable until the released device has stopped driving the bus. A read to the same bank carries no such penalty.

Top module: `erc_read_ctrl`

## Requirements
- R1: During and after reset, all chip enables and the output enable are high, `rsp_valid` is low and `req_ready` is high.
- R2: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low from the next cycle until the response strobe.
- R3: From the cycle after acceptance until the capture edge, exactly the chip enable `mem_ce_n[bank]` is low, all others stay high, and `mem_addr` equals the request address.
- R4: Output enable goes low no earlier than (access − oe) cycles after chip enable went low, and it is low only while a chip enable is low.
- R5: Data is captured on the first edge where chip enable has been low for `access` cycles and output enable for `oe` cycles. `rsp_valid` is high for exactly the following cycle, with `rsp_data` holding the captured bus value. With no turnaround, acceptance-to-strobe latency is `access` cycles.
- R6: Grade code 0 gives access/oe/float = 80/50/50 ns, code 1 gives 100/60/60 ns, and codes 2 and 3 give 120/70/70 ns. These are rounded up to whole clock periods, which at 125 MHz is 10/7/7, 13/8/8 and 15/9/9 cycles.
- R7: When the read targets a different bank from the previous read, output enable stays high until at least `float` cycles (of the previous read's grade) after the previous capture edge.
- R8: A read to the same bank as the previous one is not delayed by the float window.
- R9: The address and chip enable do not change between the output-enable assertion and the capture edge. Both chip enable and output enable return high in the cycle after capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_addr | input | 17 | Word address of the read |
| req_bank | input | 2 | Device (bank) number |
| req_grade | input | 2 | Speed-grade code selecting the timing preset |
| rsp_valid | output | 1 | One-cycle strobe, read data available |
| rsp_data | output | 16 | Captured read data |
| mem_addr | output | 17 | Address to the devices |
| mem_ce_n | output | 4 | Active-low chip enable, one per bank |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_rdata | input | 16 | Shared data bus from the devices |

## Verification
A cycle-counting device model drives garbage onto the bus unless one device has been selected, enabled and addressed for its full windows. A controller that samples early or shortens a window therefore returns a wrong word. The model also flags any output enable that starts while another bank is still inside its float time. This catches a controller that skips or shortens the turnaround on a bank change. Back-to-back reads to the same bank check that no turnaround is added, which would show as a late strobe. Each of the four grade codes is exercised, so a wrong preset or a missing mapping for code 3 shows up as a wrong latency.

// File: rtl/erc_pkg.sv
package erc_pkg;

    localparam int ERC_CNT_W = 8;

    // nanosecond presets per speed grade
    localparam int FAST_ACC_NS = 80;
    localparam int FAST_OE_NS  = 50;
    localparam int FAST_FLT_NS = 50;
    localparam int MID_ACC_NS  = 100;
    localparam int MID_OE_NS   = 60;
    localparam int MID_FLT_NS  = 60;
    localparam int SLOW_ACC_NS = 120;
    localparam int SLOW_OE_NS  = 70;
    localparam int SLOW_FLT_NS = 70;

    typedef enum logic [1:0] {
        GRADE_FAST = 2'd0,
        GRADE_MID  = 2'd1,
        GRADE_SLOW = 2'd2,
        GRADE_SLOW_ALT = 2'd3
    } erc_grade_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } erc_state_e;

    typedef struct packed {
        logic [ERC_CNT_W-1:0] acc;
        logic [ERC_CNT_W-1:0] oe;
        logic [ERC_CNT_W-1:0] flt;
    } erc_timing_t;

    // round a delay up to whole clock periods, saturating at counter range
    function automatic logic [ERC_CNT_W-1:0] ns_to_cycles(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        if (c > (1 << ERC_CNT_W) - 1)
            c = (1 << ERC_CNT_W) - 1;
        return c[ERC_CNT_W-1:0];
    endfunction

    function automatic erc_timing_t make_timing(input int acc_ns, input int oe_ns,
                                                input int flt_ns, input int clk_ps);
        erc_timing_t t;
        t.acc = ns_to_cycles(acc_ns, clk_ps);
        t.oe  = ns_to_cycles(oe_ns, clk_ps);
        t.flt = ns_to_cycles(flt_ns, clk_ps);
        return t;
    endfunction

endpackage

// File: rtl/erc_timing_sel.sv
module erc_timing_sel
    import erc_pkg::*;
#(
    parameter int CLK_PS = 8000
) (
    input  logic [1:0]  grade,
    output erc_timing_t timing
);
    localparam int N_PRESET = 3;

    erc_timing_t preset [N_PRESET];

    // one preset entry per supported speed grade
    for (genvar g = 0; g < N_PRESET; g++) begin : g_preset
        if (g == 0) begin : g_fast
            assign preset[g] = make_timing(FAST_ACC_NS, FAST_OE_NS, FAST_FLT_NS, CLK_PS);
        end else if (g == 1) begin : g_mid
            assign preset[g] = make_timing(MID_ACC_NS, MID_OE_NS, MID_FLT_NS, CLK_PS);
        end else begin : g_slow
            assign preset[g] = make_timing(SLOW_ACC_NS, SLOW_OE_NS, SLOW_FLT_NS, CLK_PS);
        end
    end

    // R6: codes 2 and 3 both select the slowest preset
    always_comb begin
        case (erc_grade_e'(grade))
            GRADE_FAST: timing = preset[0];
            GRADE_MID:  timing = preset[1];
            default:    timing = preset[2];
        endcase
    end

endmodule

// File: rtl/erc_age_counter.sv
module erc_age_counter #(
    parameter int W        = 8,
    parameter bit RST_FULL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         run,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] FULL = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    // counts elapsed clock periods since start; start loads one
    always_ff @(posedge clk) begin
        if (rst)
            count <= RST_FULL ? FULL : '0;
        else if (start)
            count <= ONE;
        else if (run && count != FULL)
            count <= count + ONE;
    end

    a_r5_count_monotonic: assert property (@(posedge clk) disable iff (rst)
        (!start && run && $past(!rst)) |=> (count >= $past(count)));

endmodule

// File: rtl/erc_bank_decode.sv
module erc_bank_decode #(
    parameter int BANKS  = 4,
    parameter int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_next,
    input  logic [BANK_W-1:0] bank_next,
    output logic [BANKS-1:0]  ce_n
);
    // registered, glitch-free select per device
    for (genvar i = 0; i < BANKS; i++) begin : g_ce
        always_ff @(posedge clk) begin
            if (rst)
                ce_n[i] <= 1'b1;
            else
                ce_n[i] <= !(en_next && (bank_next == BANK_W'(i)));
        end
    end

    a_r3_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ce_n));

endmodule

// File: rtl/erc_read_ctrl.sv
module erc_read_ctrl
    import erc_pkg::*;
#(
    parameter int CLK_PS = 8000,
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int BANKS  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [$clog2(BANKS)-1:0] req_bank,
    input  logic [1:0]               req_grade,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_data,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [BANKS-1:0]         mem_ce_n,
    output logic                     mem_oe_n,
    input  logic [DATA_W-1:0]        mem_rdata
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int CW     = ERC_CNT_W;

    erc_state_e          state_q;
    erc_timing_t         t_sel;
    erc_timing_t         t_q;
    logic [BANK_W-1:0]   bank_q;
    logic [BANK_W-1:0]   last_bank_q;
    logic [CW-1:0]       fl_lim_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                oe_on_q;
    logic [CW-1:0]       ce_age;
    logic [CW-1:0]       oe_age;
    logic [CW-1:0]       fl_age;
    logic [CW-1:0]       oe_lead;
    logic                accept;
    logic                float_ok;
    logic                oe_go;
    logic                capture;
    logic                sel_next;
    logic [BANK_W-1:0]   bank_next;
    logic                rsp_valid_q;
    logic [DATA_W-1:0]   rsp_data_q;

    erc_timing_sel #(.CLK_PS(CLK_PS)) i_timing (
        .grade  (req_grade),
        .timing (t_sel)
    );

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign oe_lead  = (t_q.acc > t_q.oe) ? (t_q.acc - t_q.oe) : '0;
    assign float_ok = (bank_q == last_bank_q) || (fl_age >= fl_lim_q);
    assign oe_go    = (state_q == ST_ACCESS) && !oe_on_q && (ce_age >= oe_lead) && float_ok;
    assign capture  = (state_q == ST_ACCESS) && oe_on_q &&
                      (ce_age >= t_q.acc) && (oe_age >= t_q.oe);

    // cycles since the chip enable fell
    erc_age_counter #(.W(CW), .RST_FULL(1'b0)) i_ce_age (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .run   (state_q == ST_ACCESS),
        .count (ce_age)
    );

    // cycles since the output enable fell
    erc_age_counter #(.W(CW), .RST_FULL(1'b0)) i_oe_age (
        .clk   (clk),
        .rst   (rst),
        .start (oe_go),
        .run   (oe_on_q),
        .count (oe_age)
    );

    // cycles since the last device was released
    erc_age_counter #(.W(CW), .RST_FULL(1'b1)) i_fl_age (
        .clk   (clk),
        .rst   (rst),
        .start (capture),
        .run   (1'b1),
        .count (fl_age)
    );

    assign sel_next  = accept || ((state_q == ST_ACCESS) && !capture);
    assign bank_next = accept ? req_bank : bank_q;

    erc_bank_decode #(.BANKS(BANKS), .BANK_W(BANK_W)) i_decode (
        .clk       (clk),
        .rst       (rst),
        .en_next   (sel_next),
        .bank_next (bank_next),
        .ce_n      (mem_ce_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            t_q         <= '0;
            bank_q      <= '0;
            last_bank_q <= '0;
            fl_lim_q    <= '0;
            addr_q      <= '0;
            oe_on_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= capture;
            if (accept) begin
                state_q <= ST_ACCESS;
                t_q     <= t_sel;
                bank_q  <= req_bank;
                addr_q  <= req_addr;
            end
            if (oe_go)
                oe_on_q <= 1'b1;
            if (capture) begin
                state_q     <= ST_IDLE;
                oe_on_q     <= 1'b0;
                rsp_data_q  <= mem_rdata;
                last_bank_q <= bank_q;
                fl_lim_q    <= t_q.flt;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign mem_addr  = addr_q;
    assign mem_oe_n  = !oe_on_q;

    a_r2_ready_drop_on_accept: assert property (@(posedge clk) disable iff (rst)
        $fell(req_ready) |-> $past(req_valid));

    a_r4_oe_needs_select: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_ce_n != '1));

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |=> $stable(mem_addr));

    a_r9_release_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (mem_oe_n && (mem_ce_n == '1)));

endmodule

// File: tb/test_erc_read_ctrl.sv
module test_erc_read_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [16:0] req_addr = '0;
    logic [1:0]  req_bank = '0;
    logic [1:0]  req_grade = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [16:0] mem_addr;
    logic [3:0]  mem_ce_n;
    logic        mem_oe_n;
    logic [15:0] mem_rdata = 16'hDEAD;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit run_mon = 0;

    erc_read_ctrl i_erc_read_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bank(req_bank), .req_grade(req_grade),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_rdata(mem_rdata)
    );

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int g_acc(input int g); return (g == 0) ? 10 : (g == 1) ? 13 : 15; endfunction
    function automatic int g_oe (input int g); return (g == 0) ? 7  : (g == 1) ? 8  : 9;  endfunction
    function automatic int g_flt(input int g); return (g == 0) ? 7  : (g == 1) ? 8  : 9;  endfunction
    function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction
    function automatic logic [15:0] dat(input int b, input logic [16:0] a);
        logic [1:0] bb = b[1:0];
        return a[15:0] ^ {bb, 14'h0} ^ {15'h0, a[16]};
    endfunction

    typedef struct { logic [15:0] data; int cyc; string tag; } exp_t;
    exp_t sb[$];

    // expected waveform of the access in flight
    int cur_ea = 0, cur_eo = 0, cur_ec = 0, cur_bank = 0, cur_grade = 0;
    logic [16:0] cur_addr = '0;
    bit have_prev = 0;
    int prev_bank = 0, prev_ec = 0, prev_f = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // driver: issue one read, compute expected timing, push to scoreboard
    task automatic rd(input int b, input logic [16:0] a, input int g, input int gap, input string tag);
        int ea, eo, ec;
        repeat (gap) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_bank = b[1:0]; req_grade = g[1:0];
        while (!req_ready) @(negedge clk);
        ea = cyc + 1;
        eo = imax(ea + g_acc(g) - g_oe(g), ea + 1);
        if (have_prev && b != prev_bank) eo = imax(eo, prev_ec + prev_f);
        ec = imax(ea + g_acc(g), eo + g_oe(g));
        cur_ea = ea; cur_eo = eo; cur_ec = ec; cur_bank = b; cur_addr = a; cur_grade = g;
        sb.push_back('{dat(b, a), ec, tag});
        have_prev = 1; prev_bank = b; prev_ec = ec; prev_f = g_flt(g);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2", "ready while busy", int'(req_ready), 0);
    endtask

    // device array model with float tracking
    int ce_cnt[4], oe_cnt[4], rel_cnt[4], rel_f[4];
    int addr_cnt = 0;
    logic [16:0] last_addr = '0;
    initial for (int k = 0; k < 4; k++) begin
        ce_cnt[k] = 0; oe_cnt[k] = 0; rel_cnt[k] = 1000; rel_f[k] = 0;
    end

    always @(negedge clk) if (run_mon) begin
        int drv_n;
        int drv_b;
        drv_n = 0; drv_b = 0;
        addr_cnt = (mem_addr == last_addr) ? addr_cnt + 1 : 1;
        last_addr = mem_addr;
        for (int b = 0; b < 4; b++) begin
            ce_cnt[b] = !mem_ce_n[b] ? ce_cnt[b] + 1 : 0;
            oe_cnt[b] = (!mem_ce_n[b] && !mem_oe_n) ? oe_cnt[b] + 1 : 0;
        end
        for (int b = 0; b < 4; b++) if (oe_cnt[b] == 1) begin
            for (int k = 0; k < 4; k++) if (k != b)
                check(rel_cnt[k] >= rel_f[k], "R7", "bus turnaround cycles", rel_cnt[k], rel_f[k]);
        end
        for (int b = 0; b < 4; b++) begin
            if (oe_cnt[b] > 0) begin
                rel_cnt[b] = 0; rel_f[b] = g_flt(cur_grade); drv_n++; drv_b = b;
            end else if (rel_cnt[b] < 1000) begin
                rel_cnt[b]++;
            end
        end
        if (drv_n == 1 && ce_cnt[drv_b] >= g_acc(cur_grade) && oe_cnt[drv_b] >= g_oe(cur_grade)
            && addr_cnt >= g_acc(cur_grade))
            mem_rdata = dat(drv_b, mem_addr);
        else
            mem_rdata = 16'hDEAD;
    end

    // pin monitor: select, enable and address against the expected window
    always @(negedge clk) if (run_mon) begin
        logic [3:0] exp_ce;
        bit exp_oe_n;
        exp_ce = (cyc >= cur_ea && cyc < cur_ec) ? ~(4'b1 << cur_bank) : 4'hF;
        exp_oe_n = !(cyc >= cur_eo && cyc < cur_ec);
        if (mem_ce_n != exp_ce)
            check(0, "R3", "chip enables", int'(mem_ce_n), int'(exp_ce));
        if (mem_oe_n != exp_oe_n)
            check(0, "R4", "output enable", int'(mem_oe_n), int'(exp_oe_n));
        if (cyc >= cur_ea && cyc < cur_ec && mem_addr != cur_addr)
            check(0, "R9", "address held", int'(mem_addr), int'(cur_addr));
    end

    // response monitor: scoreboard compare of data and strobe cycle
    always @(negedge clk) if (run_mon && rsp_valid) begin
        exp_t e;
        if (sb.size() == 0) begin
            check(0, "R5", "unexpected strobe", 1, 0);
        end else begin
            e = sb.pop_front();
            check(rsp_data == e.data, "R5", {e.tag, " data"}, int'(rsp_data), int'(e.data));
            check(cyc == e.cyc, e.tag, "strobe cycle", cyc, e.cyc);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(mem_ce_n == 4'hF, "R1", "ce in reset", int'(mem_ce_n), 15);
        check(mem_oe_n == 1'b1, "R1", "oe in reset", int'(mem_oe_n), 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        run_mon = 1;
        // R6: each grade code, isolated reads
        rd(0, 17'h00012, 0, 0, "R6");
        rd(1, 17'h10034, 1, 20, "R6");
        rd(2, 17'h00456, 2, 20, "R6");
        rd(3, 17'h1ABCD, 3, 20, "R6");
        // R8: back-to-back same bank
        rd(2, 17'h00100, 0, 20, "R8");
        rd(2, 17'h00101, 0, 0, "R8");
        rd(2, 17'h00102, 1, 0, "R8");
        // R7: back-to-back across banks, mixed grades
        rd(0, 17'h00200, 0, 0, "R7");
        rd(1, 17'h00201, 0, 0, "R7");
        rd(3, 17'h00202, 2, 0, "R7");
        rd(0, 17'h00203, 0, 0, "R7");
        rd(3, 17'h10204, 1, 0, "R7");
        // R5: bank change after a long idle gap has no penalty
        rd(1, 17'h00300, 0, 30, "R5");
        rd(2, 17'h00301, 2, 30, "R5");
        repeat (40) @(negedge clk);
        check(sb.size() == 0, "R5", "responses outstanding", sb.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule